// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits between instruction fetch and decode. It looks at one fetch word and checks its two lowest bits. If both are set, the word is a full-width instruction and it passes through unchanged. Any other value marks a 16-bit compressed instruction in the low half. The block rebuilds that instruction as the equivalent 32-bit base-ISA encoding. It puts the scattered immediate bits back in order and turns 3-bit register aliases into full register numbers. Encodings it does not support, and reserved ones, are flagged as illegal.

Each result carries the program-counter step for its instruction: 2 for a compressed form and 4 otherwise. The fetch stage uses this step to form the next sequential address. The jump-and-link forms use the same step for the return address they write. A single registered stage with a valid/ready handshake on both sides holds each result until downstream accepts it. A result appears one clock after its input is accepted.

Top module: `cexpand`

## Requirements
- R1: A fetch word whose bits 1:0 are 11 appears unchanged on `out_instr`, with `out_compressed`=0, `out_pc_inc`=4 and `out_illegal`=0.
- R2: A fetch word whose bits 1:0 are not 11 gives `out_compressed`=1 and `out_pc_inc`=2. Only bits 15:0 are used.
- R3: The following compressed words are illegal:
  - the all-zero word;
  - quadrant 00 with funct3 (bits 15:13) other than 010 or 110;
  - quadrant 01 with funct3 100;
  - quadrant 10 with funct3 other than 010, 100 or 110.

  An illegal word sets `out_illegal`=1 and `out_instr`=0.
- R4: Quadrant 00 funct3 010 expands to LW and funct3 110 expands to SW.
  - Aliases: bits 9:7 give the base register and bits 4:2 give the data register, each as 8 plus the field.
  - Zero-extended offset: bit 6 gives offset bit 2, bits 12:10 give offset bits 5:3, and bit 5 gives offset bit 6.
- R5: Quadrant 10 funct3 010 expands to LW from base x2. The destination is bits 11:7, and a destination of x0 is illegal. The offset takes bits 6:4 as 4:2, bit 12 as 5, and bits 3:2 as 7:6.
  Funct3 110 expands to SW to base x2, with the source register in bits 6:2. The offset takes bits 12:9 as 5:2 and bits 8:7 as 7:6.
- R6: Quadrant 01 builds a 6-bit signed immediate from bit 12 (sign) and bits 6:2.
  - Funct3 000 expands to ADDI rd,rd,imm.
  - Funct3 010 expands to ADDI rd,x0,imm.
  - In both, rd is bits 11:7.
- R7: Quadrant 01 funct3 011 depends on rd (bits 11:7).
  - With rd=2 it expands to ADDI x2,x2,imm. The signed immediate takes bit 6 as 4, bit 2 as 5, bit 5 as 6, bits 4:3 as 8:7 and bit 12 as 9 (sign).
  - With any other rd it expands to LUI rd, with the 6-bit signed value {bit 12, bits 6:2} as the upper immediate.
  - A zero immediate is illegal in both cases.
- R8: Quadrant 01 funct3 101 expands to JAL x0 and funct3 001 expands to JAL x1.
  - The signed offset takes bits 5:3 as 3:1, bit 11 as 4, bit 2 as 5, bit 7 as 6, bit 6 as 7, bits 10:9 as 9:8, bit 8 as 10 and bit 12 as 11 (sign).
- R9: Quadrant 01 funct3 110 expands to BEQ and funct3 111 to BNE. Both compare alias register 8+bits 9:7 with x0.
  - The signed offset takes bits 4:3 as 2:1, bits 11:10 as 4:3, bit 2 as 5, bits 6:5 as 7:6 and bit 12 as 8 (sign).
- R10: In quadrant 10 funct3 100, let b = bit 12, rd = bits 11:7 and rs = bits 6:2.
  - b=0, rs=0, rd≠0: JALR x0,0(rd).
  - b=1, rs=0, rd≠0: JALR x1,0(rd).
  - b=1, rd=0, rs=0: EBREAK.
  - b=0, rd≠0, rs≠0: ADD rd,x0,rs.
  - b=1, rd≠0, rs≠0: ADD rd,rd,rs.
  - Every other combination is illegal.
- R11: `in_ready` is high whenever the output stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold. An accepted word produces its result one clock later.
- R12: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Fetch word present |
| in_ready | output | 1 | Stage can take a word |
| in_word | input | 32 | Fetch word |
| out_ready | input | 1 | Downstream takes the result |
| out_valid | output | 1 | Result present |
| out_instr | output | 32 | Expanded instruction (0 when illegal) |
| out_compressed | output | 1 | Input was a 16-bit form |
| out_illegal | output | 1 | Input was not a supported encoding |
| out_pc_inc | output | 3 | Program-counter step, 2 or 4 |

## Verification
Some properties are checked on every cycle by assertions:
- the holding of outputs under backpressure and the one-cycle acceptance latency;
- the link between the compressed flag and the PC step;
- the zeroing of illegal results;
- that every legal result is a full-width encoding.

The correctness of each rebuilt immediate and register alias, and the exact boundaries of the illegal classes, can only be shown by the bench. It sweeps all 49152 compressed words through the stage and compares each one with an arithmetic model. Passthrough words, the all-zero word and a stall sequence are covered as separate scenarios.

// File: rtl/cexpand.sv
module cexpand (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [31:0] out_instr,
  output logic        out_compressed,
  output logic        out_illegal,
  output logic [2:0]  out_pc_inc
);

  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_IMM   = 7'b0010011;
  localparam logic [6:0] OP_LUI   = 7'b0110111;
  localparam logic [6:0] OP_JALR  = 7'b1100111;
  localparam logic [6:0] OP_REG   = 7'b0110011;
  localparam logic [31:0] EBREAK_W = 32'h0010_0073;

  function automatic logic [31:0] f_i(input logic [11:0] imm, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] f_s(input logic [11:0] imm, input logic [4:0] rs2,
                                      input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OP_STORE};
  endfunction

  function automatic logic [31:0] f_b(input logic [12:0] imm, input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] f_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction

  logic [15:0] c;
  logic [1:0]  quad;
  logic [2:0]  f3;
  logic [4:0]  rd, rs, ra, rb;
  logic        is_c;
  logic [11:0] imm6, sp16, lw_off, lwsp_off, swsp_off;
  logic [19:0] upper;
  logic [20:0] joff;
  logic [12:0] boff;
  logic [31:0] ex;
  logic        ill;

  assign c    = in_word[15:0];
  assign quad = c[1:0];
  assign f3   = c[15:13];
  assign rd   = c[11:7];
  assign rs   = c[6:2];
  assign ra   = {2'b01, c[9:7]};
  assign rb   = {2'b01, c[4:2]};
  assign is_c = quad != 2'b11;

  assign imm6     = {{7{c[12]}}, c[6:2]};
  assign sp16     = {{3{c[12]}}, c[4:3], c[5], c[2], c[6], 4'b0};
  assign upper    = {{15{c[12]}}, c[6:2]};
  assign lw_off   = {5'b0, c[5], c[12:10], c[6], 2'b0};
  assign lwsp_off = {4'b0, c[3:2], c[12], c[6:4], 2'b0};
  assign swsp_off = {4'b0, c[8:7], c[12:9], 2'b0};
  assign joff     = {{10{c[12]}}, c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
  assign boff     = {{5{c[12]}}, c[6:5], c[2], c[11:10], c[4:3], 1'b0};

  always_comb begin
    ex  = '0;
    ill = 1'b0;
    unique case (quad)
      2'b11: ex = in_word;
      2'b00: begin
        unique case (f3)
          3'b010:  ex = f_i(lw_off, ra, 3'b010, rb, OP_LOAD);
          3'b110:  ex = f_s(lw_off, rb, ra, 3'b010);
          default: ill = 1'b1;
        endcase
      end
      2'b01: begin
        unique case (f3)
          3'b000: ex = f_i(imm6, rd, 3'b000, rd, OP_IMM);
          3'b001: ex = f_j(joff, 5'd1);
          3'b010: ex = f_i(imm6, 5'd0, 3'b000, rd, OP_IMM);
          3'b011: begin
            if (rd == 5'd2) begin
              ill = sp16 == 12'd0;
              ex  = f_i(sp16, 5'd2, 3'b000, 5'd2, OP_IMM);
            end else begin
              ill = {c[12], c[6:2]} == 6'd0;
              ex  = {upper, rd, OP_LUI};
            end
          end
          3'b101:  ex = f_j(joff, 5'd0);
          3'b110:  ex = f_b(boff, ra, 3'b000);
          3'b111:  ex = f_b(boff, ra, 3'b001);
          default: ill = 1'b1;
        endcase
      end
      default: begin
        unique case (f3)
          3'b010: begin
            ill = rd == 5'd0;
            ex  = f_i(lwsp_off, 5'd2, 3'b010, rd, OP_LOAD);
          end
          3'b110: ex = f_s(swsp_off, rs, 5'd2, 3'b010);
          3'b100: begin
            unique casez ({c[12], rd != 5'd0, rs != 5'd0})
              3'b010:  ex = f_i(12'd0, rd, 3'b000, 5'd0, OP_JALR);
              3'b110:  ex = f_i(12'd0, rd, 3'b000, 5'd1, OP_JALR);
              3'b100:  ex = EBREAK_W;
              3'b011:  ex = {7'd0, rs, 5'd0, 3'b000, rd, OP_REG};
              3'b111:  ex = {7'd0, rs, rd, 3'b000, rd, OP_REG};
              default: ill = 1'b1;
            endcase
          end
          default: ill = 1'b1;
        endcase
      end
    endcase
    if (ill) ex = '0;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_instr      <= '0;
      out_compressed <= 1'b0;
      out_illegal    <= 1'b0;
      out_pc_inc     <= 3'd4;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_instr      <= ex;
        out_compressed <= is_c;
        out_illegal    <= ill;
        out_pc_inc     <= is_c ? 3'd2 : 3'd4;
      end
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_instr) && $stable(out_illegal) && $stable(out_pc_inc));
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  assert_full_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_compressed |-> out_pc_inc == 3'd4 && !out_illegal);
  assert_short_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_compressed |-> out_pc_inc == 3'd2);
  assert_zero_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_instr == 32'd0);
  assert_wide_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> out_instr[1:0] == 2'b11);
  assert_reset_R12: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/tb_cexpand.sv
`timescale 1ns/1ps
module tb_cexpand;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_word = '0;
  logic out_ready = 1'b1;
  logic out_valid;
  logic [31:0] out_instr;
  logic out_compressed, out_illegal;
  logic [2:0] out_pc_inc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cexpand dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_ready(out_ready), .out_valid(out_valid), .out_instr(out_instr),
    .out_compressed(out_compressed), .out_illegal(out_illegal), .out_pc_inc(out_pc_inc)
  );

  function automatic logic [31:0] mk_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
    logic [31:0] v = imm;
    logic [31:0] r;
    r = 32'(op);
    r[11:7] = 5'(rd); r[14:12] = 3'(f3); r[19:15] = 5'(rs1); r[31:20] = v[11:0];
    return r;
  endfunction

  function automatic logic [31:0] mk_s(int imm, int rs2, int rs1);
    logic [31:0] v = imm;
    logic [31:0] r;
    r = 32'h23;
    r[11:7] = v[4:0]; r[14:12] = 3'd2; r[19:15] = 5'(rs1); r[24:20] = 5'(rs2); r[31:25] = v[11:5];
    return r;
  endfunction

  function automatic logic [31:0] mk_b(int imm, int rs1, int f3);
    logic [31:0] v = imm;
    logic [31:0] r;
    r = 32'h63;
    r[7] = v[11]; r[11:8] = v[4:1]; r[14:12] = 3'(f3); r[19:15] = 5'(rs1);
    r[30:25] = v[10:5]; r[31] = v[12];
    return r;
  endfunction

  function automatic logic [31:0] mk_j(int imm, int rd);
    logic [31:0] v = imm;
    logic [31:0] r;
    r = 32'h6F;
    r[11:7] = 5'(rd); r[19:12] = v[19:12]; r[20] = v[11]; r[30:21] = v[10:1]; r[31] = v[20];
    return r;
  endfunction

  // returns {illegal, instr}
  function automatic logic [32:0] model(logic [31:0] w, output string tag);
    logic [15:0] c = w[15:0];
    int rd = int'(c[11:7]);
    int rs = int'(c[6:2]);
    int ra = 8 + int'(c[9:7]);
    int rb = 8 + int'(c[4:2]);
    int s6 = int'(c[6:2]) - (c[12] ? 32 : 0);
    int off, jo, bo, a;
    logic ill = 1'b0;
    logic [31:0] ins = '0;
    jo = 2*int'(c[5:3]) + 16*int'(c[11]) + 32*int'(c[2]) + 64*int'(c[7]) + 128*int'(c[6])
       + 256*int'(c[10:9]) + 1024*int'(c[8]) - (c[12] ? 2048 : 0);
    bo = 2*int'(c[4:3]) + 8*int'(c[11:10]) + 32*int'(c[2]) + 64*int'(c[6:5]) - (c[12] ? 256 : 0);
    tag = "R3";
    if (w[1:0] == 2'b11) begin
      tag = "R1";
      return {1'b0, w};
    end
    case ({c[1:0], c[15:13]})
      5'b00_010: begin tag = "R4"; off = 4*int'(c[6]) + 8*int'(c[12:10]) + 64*int'(c[5]); ins = mk_i(off, ra, 2, rb, 7'h03); end
      5'b00_110: begin tag = "R4"; off = 4*int'(c[6]) + 8*int'(c[12:10]) + 64*int'(c[5]); ins = mk_s(off, rb, ra); end
      5'b01_000: begin tag = "R6"; ins = mk_i(s6, rd, 0, rd, 7'h13); end
      5'b01_010: begin tag = "R6"; ins = mk_i(s6, 0, 0, rd, 7'h13); end
      5'b01_001: begin tag = "R8"; ins = mk_j(jo, 1); end
      5'b01_101: begin tag = "R8"; ins = mk_j(jo, 0); end
      5'b01_110: begin tag = "R9"; ins = mk_b(bo, ra, 0); end
      5'b01_111: begin tag = "R9"; ins = mk_b(bo, ra, 1); end
      5'b01_011: begin
        tag = "R7";
        if (rd == 2) begin
          a = 16*int'(c[6]) + 32*int'(c[2]) + 64*int'(c[5]) + 128*int'(c[4:3]) - (c[12] ? 512 : 0);
          if (a == 0) ill = 1'b1; else ins = mk_i(a, 2, 0, 2, 7'h13);
        end else begin
          if (s6 == 0) ill = 1'b1;
          else begin ins = 32'h37; ins[11:7] = 5'(rd); ins[31:12] = 20'(s6); end
        end
      end
      5'b10_010: begin
        tag = "R5";
        off = 4*int'(c[6:4]) + 32*int'(c[12]) + 64*int'(c[3:2]);
        if (rd == 0) ill = 1'b1; else ins = mk_i(off, 2, 2, rd, 7'h03);
      end
      5'b10_110: begin tag = "R5"; off = 4*int'(c[12:9]) + 64*int'(c[8:7]); ins = mk_s(off, rs, 2); end
      5'b10_100: begin
        tag = "R10";
        if (!c[12] && rs == 0 && rd != 0)      ins = mk_i(0, rd, 0, 0, 7'h67);
        else if (c[12] && rs == 0 && rd != 0)  ins = mk_i(0, rd, 0, 1, 7'h67);
        else if (c[12] && rs == 0 && rd == 0)  ins = 32'h0010_0073;
        else if (!c[12] && rs != 0 && rd != 0) begin ins = 32'h33; ins[11:7] = 5'(rd); ins[24:20] = 5'(rs); end
        else if (c[12] && rs != 0 && rd != 0)  begin ins = 32'h33; ins[11:7] = 5'(rd); ins[19:15] = 5'(rd); ins[24:20] = 5'(rs); end
        else ill = 1'b1;
      end
      default: ill = 1'b1;
    endcase
    if (ill) begin ins = '0; tag = "R3"; end
    return {ill, ins};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors < 40) $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_result(logic [31:0] w);
    string tag;
    logic [32:0] m = model(w, tag);
    logic is_c = w[1:0] != 2'b11;
    chk(tag, {26'd0, out_valid, out_illegal, out_compressed, out_pc_inc, out_instr},
             {26'd0, 1'b1, m[32], is_c, (is_c ? 3'd2 : 3'd4), m[31:0]});
  endtask

  logic [31:0] prev;
  logic have_prev = 1'b0;

  task automatic push(logic [31:0] w);
    @(negedge clk);
    if (have_prev) chk_result(prev);
    in_word = w; in_valid = 1'b1; prev = w; have_prev = 1'b1;
  endtask

  task automatic drain();
    @(negedge clk);
    if (have_prev) chk_result(prev);
    have_prev = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string t;
    logic [32:0] mA;
    repeat (3) @(negedge clk);
    chk("R12", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", {63'd0, out_valid}, 64'd0);

    // R3: all-zero word explicitly
    push(32'h0000_0000);
    drain();

    // full sweep of compressed words (R2..R10)
    for (int i = 0; i < 65536; i++) begin
      if (i[1:0] != 2'b11) push({16'hA5C3, 16'(i)});
    end
    drain();

    // R1: full-width passthrough
    for (int i = 0; i < 256; i++) push((32'(i) * 32'h9E37_79B1) | 32'h3);
    drain();

    // R11: backpressure
    @(negedge clk);
    out_ready = 1'b0; in_word = 32'h0000_4501; in_valid = 1'b1;
    @(negedge clk);
    mA = model(32'h0000_4501, t);
    chk("R11", {30'd0, out_valid, in_ready, out_instr}, {30'd0, 1'b1, 1'b0, mA[31:0]});
    in_word = 32'h1234_567B;
    @(negedge clk);
    chk("R11", {30'd0, out_valid, in_ready, out_instr}, {30'd0, 1'b1, 1'b0, mA[31:0]});
    out_ready = 1'b1;
    @(negedge clk);
    chk("R11", {31'd0, out_valid, out_instr}, {31'd0, 1'b1, 32'h1234_567B});
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11", {63'd0, out_valid}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule